// File: doc/BRIEF.md
# Address Pointer Override Controller

This block owns the three address counters of a frame buffer: one read pointer and two independent write pointers, named A and B. Each counter normally advances by one location per clock while the enable input is high, and it wraps back to zero after the last location of a memory of `DEPTH` words. Six active-low control pins can take over these counters. Each counter has one pin that forces it to a preset value supplied on an input bus, and a second pin that forces it to zero.

A six-bit mode vector selects the behaviour of each pin on its own. In one-shot mode, a falling edge on the pin overrides the counter for a single clock, and counting then continues from the forced value. In hold mode, the counter stays forced for as long as the pin is held low. Two capture enables let a write-pointer preset also record the loaded value in a mark register. The capture for pointer A works in every operating mode. The capture for pointer B works only when the three-bit operating mode is 4, 5, 6 or 7.

The pins come from outside the clock domain, so each one passes through a two-flop synchroniser before edges are detected. The memory array and the register decode that supplies the mode and capture bits sit outside this block.

Top module: `addr_override_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, all three pointers and both marks read zero until the first counting or override action.
- R2: When no override acts on a pointer and `en` is high, the pointer advances by one each clock and goes from `DEPTH-1` to 0. When `en` is low, the pointer holds its value.
- R3: The bits of `ovr_n` are assigned as follows: bit 5 presets the read pointer, bit 4 clears it, bit 3 presets write pointer B, bit 2 clears it, bit 1 presets write pointer A, and bit 0 clears it. A preset loads the matching `*_preset` input, which must be below `DEPTH`. A clear loads zero.
- R4: In one-shot mode (`hold_mode[i]`=0), suppose the pin is sampled low at rising edge k after being high. The override then acts at edge k+2 only, and counting resumes at the next edge even if the pin stays low.
- R5: In hold mode (`hold_mode[i]`=1), the override acts at every edge from k+2 through the edge after the pin is first sampled high again.
- R6: When the clear and the preset of one pointer act in the same cycle, the clear wins and the pointer becomes zero.
- R7: When a preset of pointer A takes effect (not overridden by its clear) and `catch_a` is 1, `mark_a` takes the loaded value in any operating mode. Otherwise `mark_a` keeps its value.
- R8: When a preset of pointer B takes effect and `catch_b` is 1, `mark_b` takes the loaded value, but only if `op_mode[2]` is 1 (modes 4 to 7). Otherwise `mark_b` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable for all pointers |
| ovr_n | input | 6 | Active-low override pins, mapped as in R3 |
| hold_mode | input | 6 | Per-pin mode: 0 one-shot, 1 hold |
| catch_a | input | 1 | Record A presets into `mark_a` |
| catch_b | input | 1 | Record B presets into `mark_b` (modes 4 to 7) |
| op_mode | input | 3 | Operating mode |
| rd_preset | input | AW | Preset value for the read pointer |
| wb_preset | input | AW | Preset value for write pointer B |
| wa_preset | input | AW | Preset value for write pointer A |
| rd_ptr | output | AW | Read pointer |
| wb_ptr | output | AW | Write pointer B |
| wa_ptr | output | AW | Write pointer A |
| mark_a | output | AW | Recorded value of pointer A |
| mark_b | output | AW | Recorded value of pointer B |

## Verification
The bench builds the block with `AW`=4 and `DEPTH`=12. This choice makes the wrap point differ from the natural roll-over of the counter, and a pointer reaches it within a dozen clocks, so free-running stretches between overrides cross it many times. With presets confined to 0 to 11, random pin toggling, mode flips and operating-mode changes often produce simultaneous set and clear, back-to-back edges, and hold periods that end right at a wrap.

// File: rtl/addr_override_ctrl.sv
module addr_override_ctrl #(
  parameter int AW    = 12,
  parameter int DEPTH = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [5:0]    ovr_n,
  input  logic [5:0]    hold_mode,
  input  logic          catch_a,
  input  logic          catch_b,
  input  logic [2:0]    op_mode,
  input  logic [AW-1:0] rd_preset,
  input  logic [AW-1:0] wb_preset,
  input  logic [AW-1:0] wa_preset,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wb_ptr,
  output logic [AW-1:0] wa_ptr,
  output logic [AW-1:0] mark_a,
  output logic [AW-1:0] mark_b
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [5:0] sync1, sync2, sync3;
  logic [5:0] fall, act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
      sync3 <= '1;
    end else begin
      sync1 <= ovr_n;
      sync2 <= sync1;
      sync3 <= sync2;
    end

  assign fall = sync3 & ~sync2;
  assign act  = (hold_mode & ~sync2) | (~hold_mode & fall);

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p,
                                              input logic [AW-1:0] pre,
                                              input logic set, input logic clr,
                                              input logic inc);
    if (clr)      return '0;
    else if (set) return pre;
    else if (inc) return (p == LAST) ? '0 : p + AW'(1);
    else          return p;
  endfunction

  logic take_a, take_b;
  assign take_a = act[1] & ~act[0] & catch_a;
  assign take_b = act[3] & ~act[2] & catch_b & op_mode[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ptr <= '0;
      wb_ptr <= '0;
      wa_ptr <= '0;
      mark_a <= '0;
      mark_b <= '0;
    end else begin
      rd_ptr <= step_ptr(rd_ptr, rd_preset, act[5], act[4], en);
      wb_ptr <= step_ptr(wb_ptr, wb_preset, act[3], act[2], en);
      wa_ptr <= step_ptr(wa_ptr, wa_preset, act[1], act[0], en);
      if (take_a) mark_a <= wa_preset;
      if (take_b) mark_b <= wb_preset;
    end

endmodule

// File: rtl/addr_override_chk.sv
module addr_override_chk #(
  parameter int AW    = 12,
  parameter int DEPTH = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [5:0]    hold_mode,
  input logic [5:0]    act,
  input logic          catch_a,
  input logic          catch_b,
  input logic [2:0]    op_mode,
  input logic [AW-1:0] rd_preset,
  input logic [AW-1:0] wa_preset,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] mark_a,
  input logic [AW-1:0] mark_b
);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act[5:4] == 2'b00) |=> rd_ptr == nxt($past(rd_ptr)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && act[5:4] == 2'b00) |=> $stable(rd_ptr));

  a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (act[5] && !act[4]) |=> rd_ptr == $past(rd_preset));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    act[4] |=> rd_ptr == '0);

  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mode[5] && act[5]) |=> (!act[5] || hold_mode[5]));

  a_r7_mark_a: assert property (@(posedge clk) disable iff (!rst_n)
    (act[1] && !act[0] && catch_a) |=> mark_a == $past(wa_preset));

  a_r8_mark_b_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mode[2] |=> $stable(mark_b));

endmodule

bind addr_override_ctrl addr_override_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .hold_mode(hold_mode), .act(act),
  .catch_a(catch_a), .catch_b(catch_b), .op_mode(op_mode),
  .rd_preset(rd_preset), .wa_preset(wa_preset),
  .rd_ptr(rd_ptr), .mark_a(mark_a), .mark_b(mark_b)
);

// File: tb/tb_addr_override_ctrl.sv
`timescale 1ns/1ps
module tb_addr_override_ctrl;
  localparam int AW = 4;
  localparam int DEPTH = 12;

  logic clk = 0, rst_n = 0, en = 0, catch_a = 0, catch_b = 0;
  logic [5:0] ovr_n = '1, hold_mode = '0;
  logic [2:0] op_mode = '0;
  logic [AW-1:0] rd_preset = '0, wb_preset = '0, wa_preset = '0;
  logic [AW-1:0] rd_ptr, wb_ptr, wa_ptr, mark_a, mark_b;

  addr_override_ctrl #(.AW(AW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ovr_n(ovr_n), .hold_mode(hold_mode),
    .catch_a(catch_a), .catch_b(catch_b), .op_mode(op_mode),
    .rd_preset(rd_preset), .wb_preset(wb_preset), .wa_preset(wa_preset),
    .rd_ptr(rd_ptr), .wb_ptr(wb_ptr), .wa_ptr(wa_ptr),
    .mark_a(mark_a), .mark_b(mark_b));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [5:0] m_s1, m_s2, m_s3;
  logic [AW-1:0] m_rd, m_wb, m_wa, m_ma, m_mb;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : AW'(int'(p) + 1);
  endfunction

  function automatic logic [AW-1:0] ref_ptr(input logic [AW-1:0] p, input logic [AW-1:0] pre,
                                            input logic s, input logic c, input logic e);
    if (c) return '0;
    if (s) return pre;
    return e ? wrap_inc(p) : p;
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = '1; m_s2 = '1; m_s3 = '1;
    m_rd = '0; m_wb = '0; m_wa = '0; m_ma = '0; m_mb = '0;
  endtask

  task automatic step();
    logic [5:0] a;
    @(posedge clk);
    a = (hold_mode & ~m_s2) | (~hold_mode & m_s3 & ~m_s2);
    m_rd = ref_ptr(m_rd, rd_preset, a[5], a[4], en);
    m_wb = ref_ptr(m_wb, wb_preset, a[3], a[2], en);
    m_wa = ref_ptr(m_wa, wa_preset, a[1], a[0], en);
    if (a[1] && !a[0] && catch_a) m_ma = wa_preset;
    if (a[3] && !a[2] && catch_b && op_mode[2]) m_mb = wb_preset;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ovr_n;
    @(negedge clk);
    check("R2 R3 R4 R5 R6 rd_ptr", rd_ptr, m_rd);
    check("R2 R3 R4 R5 R6 wb_ptr", wb_ptr, m_wb);
    check("R2 R3 R4 R5 R6 wa_ptr", wa_ptr, m_wa);
    check("R7 mark_a", mark_a, m_ma);
    check("R8 mark_b", mark_b, m_mb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 rd_ptr reset", rd_ptr, '0);
    check("R1 wa_ptr reset", wa_ptr, '0);
    check("R1 mark_b reset", mark_b, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 held after release", wb_ptr, '0);

    en = 1;
    repeat (15) step();               // R2 wrap at DEPTH-1
    check("R2 wrapped count", rd_ptr, AW'(15 % DEPTH));

    // R4 one-shot read preset, pin held low long
    rd_preset = 4'd9; ovr_n[5] = 0;
    repeat (6) step();
    ovr_n[5] = 1; repeat (3) step();

    // R5 hold-mode clear of pointer B
    hold_mode[2] = 1; ovr_n[2] = 0;
    repeat (5) step();
    check("R5 B held at zero", wb_ptr, '0);
    ovr_n[2] = 1; repeat (4) step();

    // R6 set and clear of A together, R7 no mark then
    catch_a = 1; wa_preset = 4'd7; ovr_n[1:0] = 2'b00;
    repeat (4) step();
    ovr_n[1:0] = 2'b11; repeat (3) step();
    check("R6 R7 mark_a unchanged", mark_a, '0);

    // R7 A capture in mode 0
    ovr_n[1] = 0; repeat (3) step();
    check("R7 mark_a captured", mark_a, 4'd7);
    ovr_n[1] = 1; repeat (3) step();

    // R8 B capture blocked in mode 3, allowed in mode 5
    catch_b = 1; wb_preset = 4'd5; op_mode = 3'd3; ovr_n[3] = 0;
    repeat (3) step();
    check("R8 mark_b blocked", mark_b, '0);
    ovr_n[3] = 1; repeat (3) step();
    op_mode = 3'd5; ovr_n[3] = 0; repeat (3) step();
    check("R8 mark_b captured", mark_b, 4'd5);
    ovr_n[3] = 1; repeat (3) step();

    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 6; b++)
        if ($urandom_range(0, 7) == 0) ovr_n[b] = ~ovr_n[b];
      if ($urandom_range(0, 40) == 0) hold_mode = 6'($urandom);
      en = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 20) == 0) begin catch_a = 1'($urandom); catch_b = 1'($urandom); end
      if ($urandom_range(0, 30) == 0) op_mode = 3'($urandom);
      rd_preset = AW'($urandom_range(0, DEPTH - 1));
      wb_preset = AW'($urandom_range(0, DEPTH - 1));
      wa_preset = AW'($urandom_range(0, DEPTH - 1));
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule